// File: doc/BRIEF.md
# Shared Timer Tick Prescaler and Divider

This block turns one base clock into five single-cycle tick-enable strobes, one for each channel of a five-channel timer. It contains two 8-bit prescalers. The first feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel has a 4-bit selector code. A code can pick a power-of-two post-divider applied to its group's prescaler output. A code can instead pick an external tick input that belongs to the channel's group. Every output is a clock enable in the base clock domain. External ticks are synchronised and edge-detected before they are used.

Software sets the block through a small port with two configuration words. Word 0 holds both prescaler reload values. Word 1 holds the five selector codes. A new prescaler value or division does not take effect at once: it takes effect when the stage it belongs to next reaches its terminal count. Because of this a running channel is never restarted part-way through a period.

The edge detector for each external input is a two-state machine. In `EDGE_LOW` the machine has last seen the synchronised input low. When the input is seen high it moves to `EDGE_HIGH` (transition "rise") and emits one pulse. In `EDGE_HIGH` it holds until the input is seen low, then returns to `EDGE_LOW` (transition "fall") with no pulse.

Top module: `timer_tick_gen`

## Requirements
- R1: After reset, both configuration words read zero. Every channel then ticks once every 2 base cycles: prescale by 1 and the smallest division (DIV_BASE = 1).
- R2: Word 0 (cfg_addr = 0) holds prescaler A in bits [7:0] and prescaler B in bits [15:8]. Bits [19:16] of word 0 are not stored and read as zero.
- R3: Word 1 (cfg_addr = 1) holds the 4-bit selector code of channel n in bits [4n+3:4n]. All 20 bits are stored and read back.
- R4: Channels 0 and 1 use prescaler A and channels 2 to 4 use prescaler B. A prescaler with value p gives one strobe every p+1 base cycles.
- R5: A divider code c gives a tick period of (p+1)·2^min(c+1, 4) base cycles, so the division saturates at 16. With the default mask, codes 5 to 15 saturate. A channel in divider mode never ticks on two consecutive cycles.
- R6: A code set in the external mask (default: only code 4) makes the channel tick once per rising edge of its group's external input: input 0 for channels 0 and 1, input 1 for channels 2 to 4. The tick is one cycle long and shows in the second cycle after the input goes high.
- R7: A prescaler or selector write made while running takes effect at that stage's next terminal count, and does not restart the count in progress. Example: prescaler A goes from 9 to 1 just after a channel-0 tick with code 0. The next interval is then 12 cycles, and later intervals are 4 cycles.
- R8: A channel in external mode ignores the external input of the other group, and ignores its own prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the word chosen by cfg_addr |
| cfg_addr | input | 1 | Word select: 0 for prescalers, 1 for selector codes |
| cfg_wdata | input | 20 | Write data |
| cfg_rdata | output | 20 | Read data of the word chosen by cfg_addr (combinational) |
| ext_tick_in | input | 2 | Asynchronous external tick inputs, one per group |
| tick_en_o | output | 5 | Single-cycle tick enables, one per channel |

## Verification
Read data follows cfg_addr in the same cycle, and a write can be seen on the next cycle. The bench reads back one negative edge after each write.

A divider tick is driven combinationally from the stage counters. Its period is measured as the number of negative edges from one tick to the next. Each measurement is taken only after a settling window of several full periods, so the newly latched reload values are the ones being measured.

For the external path the result is due exactly two cycles after the input rises. The bench therefore checks the three negative edges that follow a rise: no tick, then a tick, then no tick.

For the runtime-change check, the write is driven on the same negative edge at which a tick is seen. The length of the interval straddling the write is then fixed, and can be worked out by hand.

// File: rtl/timer_tick_gen_pkg.sv
package timer_tick_gen_pkg;

    // State of the external edge detector: last seen level of the synced input.
    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;

    // Clamp a selector code to a post-divider shift amount.
    function automatic int unsigned code_to_shift(
        input int unsigned code,
        input int unsigned base,
        input int unsigned max_log2
    );
        int unsigned s;
        s = code + base;
        if (s > max_log2) s = max_log2;
        return s;
    endfunction

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] reload_i,
    output logic             strobe_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit_q;

    // Terminal count: the limit is reloaded only here, so a new value never
    // cuts the running count short.
    assign strobe_o = (cnt_q == limit_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (strobe_o) begin
            cnt_q   <= '0;
            limit_q <= reload_i;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tick_ext_edge.sv
module tick_ext_edge
    import timer_tick_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);

    logic        meta_q;
    logic        sync_q;
    edge_state_e state_q;
    edge_state_e state_d;

    // Two-flop synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_LOW;
        else        state_q <= state_d;
    end

    // Next state and output.
    always_comb begin
        state_d = state_q;
        pulse_o = 1'b0;
        unique case (state_q)
            EDGE_LOW: begin
                if (sync_q) begin
                    state_d = EDGE_HIGH;
                    pulse_o = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!sync_q) state_d = EDGE_LOW;
            end
        endcase
    end

endmodule

// File: rtl/tick_postdiv.sv
module tick_postdiv
    import timer_tick_gen_pkg::*;
#(
    parameter int                  SEL_W        = 4,
    parameter int                  DIV_BASE     = 1,
    parameter int                  MAX_DIV_LOG2 = 4,
    parameter logic [2**SEL_W-1:0] EXT_MASK     = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             ext_pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o,
    output logic             is_ext_o
);

    localparam int CNT_W = (MAX_DIV_LOG2 > 0) ? MAX_DIV_LOG2 : 1;
    localparam int SH_W  = $clog2(MAX_DIV_LOG2 + 1) > 0 ? $clog2(MAX_DIV_LOG2 + 1) : 1;
    localparam logic [CNT_W-1:0] ONES = '1;
    localparam logic [SH_W-1:0]  RESET_SHIFT =
        SH_W'(code_to_shift(0, DIV_BASE, MAX_DIV_LOG2));

    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  shift_q;
    logic [SH_W-1:0]  shift_new;
    logic [CNT_W-1:0] last_idx;
    logic             wrap;

    assign shift_new = SH_W'(code_to_shift(int'(sel_i), DIV_BASE, MAX_DIV_LOG2));
    assign last_idx  = ~(ONES << shift_q);
    assign wrap      = strobe_i && (cnt_q == last_idx);
    assign is_ext_o  = EXT_MASK[sel_i];

    // The divider keeps counting in external mode, so a return to divider
    // mode resumes a consistent phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= RESET_SHIFT;
        end else if (wrap) begin
            cnt_q   <= '0;
            shift_q <= shift_new;
        end else if (strobe_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign tick_o = is_ext_o ? ext_pulse_i : wrap;

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
    parameter int                  NUM_CH       = 5,
    parameter int                  NUM_PRE      = 2,
    parameter int                  GRP_SPLIT    = 2,
    parameter int                  PRE_W        = 8,
    parameter int                  SEL_W        = 4,
    parameter int                  DIV_BASE     = 1,
    parameter int                  MAX_DIV_LOG2 = 4,
    parameter logic [2**SEL_W-1:0] EXT_MASK     = 16'h0010,
    localparam int PRE_REG_W = NUM_PRE * PRE_W,
    localparam int SEL_REG_W = NUM_CH * SEL_W,
    localparam int WORD_W    = (PRE_REG_W > SEL_REG_W) ? PRE_REG_W : SEL_REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [WORD_W-1:0]  cfg_rdata,
    input  logic [NUM_PRE-1:0] ext_tick_in,
    output logic [NUM_CH-1:0]  tick_en_o
);

    logic [PRE_REG_W-1:0] pre_q;
    logic [SEL_REG_W-1:0] sel_q;
    logic [NUM_PRE-1:0]   pre_strobe;
    logic [NUM_PRE-1:0]   ext_pulse;
    logic [NUM_CH-1:0]    ch_is_ext;

    // Configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            sel_q <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_addr) sel_q <= cfg_wdata[SEL_REG_W-1:0];
            else          pre_q <= cfg_wdata[PRE_REG_W-1:0];
        end
    end

    assign cfg_rdata = cfg_addr ? WORD_W'(sel_q) : WORD_W'(pre_q);

    // One prescaler and one external edge detector per group.
    for (genvar g = 0; g < NUM_PRE; g++) begin : g_grp
        tick_prescale #(.PRE_W(PRE_W)) pre_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload_i (pre_q[g*PRE_W +: PRE_W]),
            .strobe_o (pre_strobe[g])
        );
        tick_ext_edge ext_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_tick_in[g]),
            .pulse_o (ext_pulse[g])
        );
    end

    // Per-channel post-divider and source select.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP_SPLIT) ? 0 : 1;
        tick_postdiv #(
            .SEL_W        (SEL_W),
            .DIV_BASE     (DIV_BASE),
            .MAX_DIV_LOG2 (MAX_DIV_LOG2),
            .EXT_MASK     (EXT_MASK)
        ) div_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .strobe_i    (pre_strobe[GRP]),
            .ext_pulse_i (ext_pulse[GRP]),
            .sel_i       (sel_q[c*SEL_W +: SEL_W]),
            .tick_o      (tick_en_o[c]),
            .is_ext_o    (ch_is_ext[c])
        );
    end

endmodule

// File: rtl/timer_tick_gen_chk.sv
module timer_tick_gen_chk #(
    parameter int NUM_CH    = 5,
    parameter int NUM_PRE   = 2,
    parameter int GRP_SPLIT = 2,
    parameter int DIV_BASE  = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CH-1:0]  tick,
    input logic [NUM_CH-1:0]  ch_is_ext,
    input logic [NUM_PRE-1:0] pre_strobe,
    input logic [NUM_PRE-1:0] ext_pulse,
    input logic [NUM_PRE-1:0] ext_in
);

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_grp
        // R6: an edge pulse lasts one cycle.
        assert_ext_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ext_pulse[g] |=> !ext_pulse[g]);
        // R6: an edge pulse needs the raw input high two cycles earlier.
        assert_ext_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ext_pulse[g] |-> $past(ext_in[g], 2));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP_SPLIT) ? 0 : 1;
        // R4: a divider tick coincides with its own group's prescaler strobe.
        assert_group_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && !ch_is_ext[c]) |-> pre_strobe[GRP]);
        // R8: an external-mode tick comes only from its own group's input.
        assert_ext_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && ch_is_ext[c]) |-> ext_pulse[GRP]);
        if (DIV_BASE > 0) begin : g_nb2b
            // R5: divider mode never ticks on two consecutive cycles.
            assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (tick[c] && !ch_is_ext[c]) |=> (ch_is_ext[c] || !tick[c]));
        end
    end

endmodule

bind timer_tick_gen timer_tick_gen_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_PRE   (NUM_PRE),
    .GRP_SPLIT (GRP_SPLIT),
    .DIV_BASE  (DIV_BASE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en_o),
    .ch_is_ext  (ch_is_ext),
    .pre_strobe (pre_strobe),
    .ext_pulse  (ext_pulse),
    .ext_in     (ext_tick_in)
);

// File: tb/timer_tick_gen_tb_top.sv
module timer_tick_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 5;
    localparam int WORD_W     = 20;
    localparam int DIV_BASE   = 1;
    localparam int MAX_LOG2   = 4;
    localparam int N_VEC      = 4;
    // {prescaler word[15:0], selector word[19:0]}
    localparam logic [35:0] VEC [N_VEC] = '{
        {16'h0000, 20'h00000},
        {16'h0402, 20'h72031},
        {16'h0009, 20'h53120},
        {16'h0103, 20'h12106}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wr_en;
    logic              cfg_addr;
    logic [WORD_W-1:0] cfg_wdata;
    logic [WORD_W-1:0] cfg_rdata;
    logic [1:0]        ext_tick_in;
    logic [NUM_CH-1:0] tick_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_tick_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .ext_tick_in (ext_tick_in),
        .tick_en_o   (tick_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic a, output logic [WORD_W-1:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic int exp_period(input int pre, input int code);
        int s;
        s = code + DIV_BASE;
        if (s > MAX_LOG2) s = MAX_LOG2;
        return (pre + 1) << s;
    endfunction

    task automatic measure(input int ch, output int per);
        int guard = 0;
        @(negedge clk);
        while (!tick_en_o[ch] && guard < 3000) begin @(negedge clk); guard++; end
        per = 0;
        do begin @(negedge clk); per++; end while (!tick_en_o[ch] && per < 3000);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] rd;
        int per;
        int cnt_a, cnt_b;
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0; ext_tick_in = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cfg_read(1'b0, rd); check(rd == 0, "R1 word0 after reset", int'(rd), 0);
        cfg_read(1'b1, rd); check(rd == 0, "R1 word1 after reset", int'(rd), 0);
        measure(0, per); check(per == 2, "R1 ch0 reset period", per, 2);
        measure(4, per); check(per == 2, "R1 ch4 reset period", per, 2);

        // R2, R3: unused bits and field widths
        cfg_write(1'b0, 20'hFFFFF);
        cfg_read(1'b0, rd); check(rd == 20'h0FFFF, "R2 word0 upper bits", int'(rd), 'h0FFFF);
        cfg_write(1'b1, 20'hFFFFF);
        cfg_read(1'b1, rd); check(rd == 20'hFFFFF, "R3 word1 all bits", int'(rd), 'hFFFFF);

        // R4, R5: table of prescaler/selector settings
        for (int v = 0; v < N_VEC; v++) begin
            cfg_write(1'b0, WORD_W'(VEC[v][35:20]));
            cfg_write(1'b1, VEC[v][19:0]);
            cfg_read(1'b0, rd); check(rd == WORD_W'(VEC[v][35:20]), "R2 word0 readback", int'(rd), int'(VEC[v][35:20]));
            cfg_read(1'b1, rd); check(rd == VEC[v][19:0], "R3 word1 readback", int'(rd), int'(VEC[v][19:0]));
            repeat (400) @(negedge clk);
            for (int c = 0; c < NUM_CH; c++) begin
                int pre, code, ep;
                pre  = (c < 2) ? int'(VEC[v][27:20]) : int'(VEC[v][35:28]);
                code = int'(VEC[v][c*4 +: 4]);
                ep   = exp_period(pre, code);
                measure(c, per);
                check(per == ep, "R4 R5 channel period", per, ep);
            end
        end

        // R7: runtime prescaler change takes effect at next terminal count
        cfg_write(1'b0, 20'h00009);
        cfg_write(1'b1, 20'h00000);
        repeat (400) @(negedge clk);
        @(negedge clk);
        while (!tick_en_o[0]) @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 1'b0; cfg_wdata = 20'h00001;
        per = 0;
        do begin
            @(negedge clk); per++;
            cfg_wr_en = 1'b0;
        end while (!tick_en_o[0] && per < 3000);
        check(per == 12, "R7 interval across change", per, 12);
        per = 0;
        do begin @(negedge clk); per++; end while (!tick_en_o[0] && per < 3000);
        check(per == 4, "R7 interval after change", per, 4);

        // R6, R8: external mode on ch0 and ch2 (code 4)
        cfg_write(1'b1, 20'h00404);
        repeat (20) @(negedge clk);
        ext_tick_in[1] = 1'b1;
        @(negedge clk); check(tick_en_o[2] == 1'b0, "R6 no tick one cycle after rise", int'(tick_en_o[2]), 0);
        @(negedge clk); check(tick_en_o[2] == 1'b1, "R6 tick two cycles after rise", int'(tick_en_o[2]), 1);
        @(negedge clk); check(tick_en_o[2] == 1'b0, "R6 tick lasts one cycle", int'(tick_en_o[2]), 0);
        repeat (4) @(negedge clk);
        ext_tick_in[1] = 1'b0;
        repeat (6) @(negedge clk);
        cnt_a = 0; cnt_b = 0;
        for (int k = 0; k < 5; k++) begin
            ext_tick_in[1] = 1'b1;
            repeat (5) begin @(negedge clk); cnt_a += int'(tick_en_o[2]); cnt_b += int'(tick_en_o[0]); end
            ext_tick_in[1] = 1'b0;
            repeat (5) begin @(negedge clk); cnt_a += int'(tick_en_o[2]); cnt_b += int'(tick_en_o[0]); end
        end
        check(cnt_a == 5, "R6 ch2 ticks per input-1 edge", cnt_a, 5);
        check(cnt_b == 0, "R8 ch0 ignores input 1", cnt_b, 0);
        cnt_a = 0; cnt_b = 0;
        for (int k = 0; k < 3; k++) begin
            ext_tick_in[0] = 1'b1;
            repeat (5) begin @(negedge clk); cnt_a += int'(tick_en_o[0]); cnt_b += int'(tick_en_o[2]); end
            ext_tick_in[0] = 1'b0;
            repeat (5) begin @(negedge clk); cnt_a += int'(tick_en_o[0]); cnt_b += int'(tick_en_o[2]); end
        end
        check(cnt_a == 3, "R6 ch0 ticks per input-0 edge", cnt_a, 3);
        check(cnt_b == 0, "R8 ch2 ignores input 0 and prescaler", cnt_b, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule